// File: doc/BRIEF.md
# Working Register File with Pointer Pairs and Data-Space Window

This block holds the general-purpose working registers of a small 8-bit RISC core. The execution stage reads two operands through two combinational ports, computes its result, and writes that result back through a single write port. The write lands on the next rising edge, so a full read-operate-write completes in one clock.

Three pairs at the top of the file act as 16-bit indirect address pointers. Each pointer has a 16-bit update port that can load it, post-increment it or pre-decrement it. The port also returns the effective address for the access. The Z pair doubles as the lookup address for constant tables held in program memory.

A unified load/store port covers a small data space. The lowest addresses reach the working registers. The addresses above them reach a bank of 64 I/O registers, which peripherals also use through a direct I/O port. Any address above the I/O window is flagged and reads as zero.

Top module: `gprf_dataspace_file`

## Requirements
- R1: The file holds 32 registers of 8 bits. Ports `ra_data` and `rb_data` show the contents of `ra_sel` and `rb_sel` combinationally, and the same register can be read, modified and written back within one clock.
- R2: When `wr_en` is 1, `wr_data` is stored into register `wr_sel` on the rising edge and is visible on the read ports after that edge.
- R3: X = {r27,r26}, Y = {r29,r28} and Z = {r31,r30}, with the lower-numbered register as the low byte. These values appear on `ptr_x`, `ptr_y` and `ptr_z`, and `ptr_z` is the table-lookup address.
- R4: `ptr_sel` selects the pointer (0 = X, 1 = Y, 2 = Z, 3 = none). With `ptr_op` = 1 (load), `ptr_wdata` is written into both bytes of the selected pointer on one edge. With `ptr_op` = 0, or with `ptr_sel` = 3, no pointer changes.
- R5: With `ptr_op` = 2 (post-increment), `ptr_addr` equals the current pointer value, and the pointer becomes that value plus 1 (0xFFFF wraps to 0x0000).
- R6: With `ptr_op` = 3 (pre-decrement), `ptr_addr` equals the current value minus 1, and the pointer takes that value (0x0000 wraps to 0xFFFF).
- R7: Data-space addresses 0x00 to 0x1F read and write register r[addr] through `ds_rdata` and `ds_we`/`ds_wdata`, with `ds_oor` = 0.
- R8: Data-space addresses 0x20 to 0x5F reach I/O register (addr − 0x20). The direct port (`io_addr` 0 to 63, `io_we`) reaches the same storage.
- R9: For a data-space address at or above 0x60, `ds_oor` = 1 and `ds_rdata` = 0, and a store changes no register.
- R10: When several writers target the same register in one cycle, the order of priority is: the ALU write, then the pointer update, then the data-space store. A direct I/O write beats a data-space store to the same I/O register. Writes to different registers all take effect.
- R11: A synchronous active-high `rst` clears every working and I/O register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ra_sel | input | 5 | Operand A register select |
| ra_data | output | 8 | Operand A value |
| rb_sel | input | 5 | Operand B register select |
| rb_data | output | 8 | Operand B value |
| wr_en | input | 1 | ALU result write enable |
| wr_sel | input | 5 | ALU result register select |
| wr_data | input | 8 | ALU result value |
| ptr_op | input | 2 | Pointer operation: 0 hold, 1 load, 2 post-inc, 3 pre-dec |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_wdata | input | 16 | Value for a pointer load |
| ptr_addr | output | 16 | Effective address of the pointer access |
| ptr_x | output | 16 | X pointer value |
| ptr_y | output | 16 | Y pointer value |
| ptr_z | output | 16 | Z pointer value, table-lookup address |
| io_we | input | 1 | Direct I/O write enable |
| io_addr | input | 6 | Direct I/O register index |
| io_wdata | input | 8 | Direct I/O write value |
| io_rdata | output | 8 | Direct I/O read value |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space store enable |
| ds_wdata | input | 8 | Data-space store value |
| ds_rdata | output | 8 | Data-space load value |
| ds_oor | output | 1 | Data-space address beyond the I/O window |

## Verification
The hardest case to reach is a same-cycle collision on one register. An example is an ALU write to r27 while X is being loaded, which leaves one pointer byte from each writer. The stimulus drives the ALU port, the pointer port and the data-space port together in a single cycle. It then reads the register back through the pointer output and the read ports.

A second hard case is a store above the window whose low address bits alias a real register or I/O index, such as 0x60 and 0x1060. Those targets are read back afterwards to show that they kept their values.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  typedef enum logic [1:0] {
    PTR_HOLD    = 2'd0,
    PTR_LOAD    = 2'd1,
    PTR_POSTINC = 2'd2,
    PTR_PREDEC  = 2'd3
  } ptr_op_e;

  typedef enum logic [1:0] {
    RGN_REG  = 2'd0,
    RGN_IO   = 2'd1,
    RGN_NONE = 2'd2
  } ds_region_e;
endpackage

// File: rtl/gprf_ds_decode.sv
module gprf_ds_decode
  import gprf_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int IO_REGS  = 64,
  localparam int REG_IDX_W = $clog2(NUM_REGS),
  localparam int IO_IDX_W  = $clog2(IO_REGS)
) (
  input  logic [ADDR_W-1:0]    ds_addr,
  input  logic                 ds_we,
  output ds_region_e           region,
  output logic [REG_IDX_W-1:0] reg_idx,
  output logic [IO_IDX_W-1:0]  io_idx,
  output logic                 reg_we,
  output logic                 io_we
);
  localparam logic [ADDR_W-1:0] IO_START = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] WIN_END  = ADDR_W'(NUM_REGS + IO_REGS);

  always_comb begin
    if (ds_addr < IO_START)     region = RGN_REG;
    else if (ds_addr < WIN_END) region = RGN_IO;
    else                        region = RGN_NONE;
  end

  // Offset into the I/O bank, taken modulo the bank size
  assign reg_idx = ds_addr[REG_IDX_W-1:0];
  assign io_idx  = ds_addr[IO_IDX_W-1:0] - IO_IDX_W'(NUM_REGS);
  assign reg_we  = ds_we && (region == RGN_REG);
  assign io_we   = ds_we && (region == RGN_IO);
endmodule

// File: rtl/gprf_ptr_unit.sv
module gprf_ptr_unit
  import gprf_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int NUM_PTRS  = 3,
  parameter int SEL_W     = 2,
  parameter int REG_IDX_W = 5,
  parameter int PTR_BASE  = 26
) (
  input  ptr_op_e                          op,
  input  logic [SEL_W-1:0]                 sel,
  input  logic [PTR_W-1:0]                 wdata,
  input  logic [NUM_PTRS-1:0][PTR_W-1:0]   cur,
  output logic                             upd,
  output logic [REG_IDX_W-1:0]             lo_idx,
  output logic [PTR_W-1:0]                 next,
  output logic [PTR_W-1:0]                 addr
);
  logic             valid;
  logic [PTR_W-1:0] cur_sel;
  logic [PTR_W-1:0] dec_val;

  assign valid = sel < SEL_W'(NUM_PTRS);

  always_comb begin
    cur_sel = '0;
    for (int k = 0; k < NUM_PTRS; k++)
      if (sel == SEL_W'(k)) cur_sel = cur[k];
  end

  assign lo_idx  = REG_IDX_W'(PTR_BASE + 2 * int'(sel));
  assign dec_val = cur_sel - PTR_W'(1);

  always_comb begin
    upd  = 1'b0;
    next = cur_sel;
    addr = cur_sel;
    unique case (op)
      PTR_HOLD:    upd = 1'b0;
      PTR_LOAD:    begin upd = valid; next = wdata; end
      PTR_POSTINC: begin upd = valid; next = cur_sel + PTR_W'(1); end
      PTR_PREDEC:  begin upd = valid; next = dec_val; addr = dec_val; end
      default:     upd = 1'b0;
    endcase
  end
endmodule

// File: rtl/gprf_io_bank.sv
module gprf_io_bank #(
  parameter int DATA_W  = 8,
  parameter int IO_REGS = 64,
  localparam int IO_IDX_W = $clog2(IO_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dir_we,
  input  logic [IO_IDX_W-1:0] dir_idx,
  input  logic [DATA_W-1:0]   dir_wdata,
  output logic [DATA_W-1:0]   dir_rdata,
  input  logic                ds_we,
  input  logic [IO_IDX_W-1:0] ds_idx,
  input  logic [DATA_W-1:0]   ds_wdata,
  output logic [DATA_W-1:0]   ds_rdata
);
  logic [DATA_W-1:0] mem [IO_REGS];
  logic              ds_blocked;

  assign ds_blocked = dir_we && (dir_idx == ds_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < IO_REGS; i++) mem[i] <= '0;
    end else begin
      if (dir_we)                 mem[dir_idx] <= dir_wdata;
      if (ds_we && !ds_blocked)   mem[ds_idx]  <= ds_wdata;
    end
  end

  assign dir_rdata = mem[dir_idx];
  assign ds_rdata  = mem[ds_idx];
endmodule

// File: rtl/gprf_core.sv
module gprf_core #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int NUM_PTRS = 3,
  parameter int PTR_BASE = 26,
  localparam int REG_IDX_W = $clog2(NUM_REGS),
  localparam int PTR_W     = 2 * DATA_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [REG_IDX_W-1:0]           ra_sel,
  output logic [DATA_W-1:0]              ra_data,
  input  logic [REG_IDX_W-1:0]           rb_sel,
  output logic [DATA_W-1:0]              rb_data,
  input  logic                           alu_we,
  input  logic [REG_IDX_W-1:0]           alu_sel,
  input  logic [DATA_W-1:0]              alu_wdata,
  input  logic                           ptr_upd,
  input  logic [REG_IDX_W-1:0]           ptr_lo_idx,
  input  logic [PTR_W-1:0]               ptr_next,
  input  logic                           ds_we,
  input  logic [REG_IDX_W-1:0]           ds_sel,
  input  logic [DATA_W-1:0]              ds_wdata,
  output logic [DATA_W-1:0]              ds_rdata,
  output logic [NUM_PTRS-1:0][PTR_W-1:0] ptr_vals
);
  logic [DATA_W-1:0]    regs [NUM_REGS];
  logic [REG_IDX_W-1:0] ptr_hi_idx;

  assign ptr_hi_idx = ptr_lo_idx + REG_IDX_W'(1);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    logic              alu_hit, plo_hit, phi_hit, ds_hit;
    logic [DATA_W-1:0] q;

    assign alu_hit = alu_we  && (alu_sel    == REG_IDX_W'(i));
    assign plo_hit = ptr_upd && (ptr_lo_idx == REG_IDX_W'(i));
    assign phi_hit = ptr_upd && (ptr_hi_idx == REG_IDX_W'(i));
    assign ds_hit  = ds_we   && (ds_sel     == REG_IDX_W'(i));

    // Priority: ALU result, then pointer update, then data-space store
    always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (alu_hit) q <= alu_wdata;
      else if (plo_hit) q <= ptr_next[DATA_W-1:0];
      else if (phi_hit) q <= ptr_next[PTR_W-1:DATA_W];
      else if (ds_hit)  q <= ds_wdata;
    end

    assign regs[i] = q;
  end

  assign ra_data  = regs[ra_sel];
  assign rb_data  = regs[rb_sel];
  assign ds_rdata = regs[ds_sel];

  for (genvar k = 0; k < NUM_PTRS; k++) begin : g_ptr
    assign ptr_vals[k] = {regs[PTR_BASE + 2*k + 1], regs[PTR_BASE + 2*k]};
  end
endmodule

// File: rtl/gprf_dataspace_file.sv
module gprf_dataspace_file
  import gprf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int IO_REGS  = 64,
  parameter int ADDR_W   = 16,
  parameter int PTR_BASE = 26,
  localparam int REG_IDX_W = $clog2(NUM_REGS),
  localparam int IO_IDX_W  = $clog2(IO_REGS),
  localparam int PTR_W     = 2 * DATA_W,
  localparam int NUM_PTRS  = 3,
  localparam int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [REG_IDX_W-1:0] ra_sel,
  output logic [DATA_W-1:0]    ra_data,
  input  logic [REG_IDX_W-1:0] rb_sel,
  output logic [DATA_W-1:0]    rb_data,
  input  logic                 wr_en,
  input  logic [REG_IDX_W-1:0] wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [1:0]           ptr_op,
  input  logic [SEL_W-1:0]     ptr_sel,
  input  logic [PTR_W-1:0]     ptr_wdata,
  output logic [PTR_W-1:0]     ptr_addr,
  output logic [PTR_W-1:0]     ptr_x,
  output logic [PTR_W-1:0]     ptr_y,
  output logic [PTR_W-1:0]     ptr_z,
  input  logic                 io_we,
  input  logic [IO_IDX_W-1:0]  io_addr,
  input  logic [DATA_W-1:0]    io_wdata,
  output logic [DATA_W-1:0]    io_rdata,
  input  logic [ADDR_W-1:0]    ds_addr,
  input  logic                 ds_we,
  input  logic [DATA_W-1:0]    ds_wdata,
  output logic [DATA_W-1:0]    ds_rdata,
  output logic                 ds_oor
);
  ds_region_e                     region;
  logic [REG_IDX_W-1:0]           ds_reg_idx;
  logic [IO_IDX_W-1:0]            ds_io_idx;
  logic                           ds_reg_we, ds_io_we;
  logic [DATA_W-1:0]              reg_ds_rdata, io_ds_rdata;
  logic [NUM_PTRS-1:0][PTR_W-1:0] ptr_vals;
  logic                           ptr_upd;
  logic [REG_IDX_W-1:0]           ptr_lo_idx;
  logic [PTR_W-1:0]               ptr_next;

  gprf_ds_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IO_REGS(IO_REGS)
  ) u_dec (
    .ds_addr(ds_addr), .ds_we(ds_we), .region(region),
    .reg_idx(ds_reg_idx), .io_idx(ds_io_idx),
    .reg_we(ds_reg_we), .io_we(ds_io_we)
  );

  gprf_ptr_unit #(
    .PTR_W(PTR_W), .NUM_PTRS(NUM_PTRS), .SEL_W(SEL_W),
    .REG_IDX_W(REG_IDX_W), .PTR_BASE(PTR_BASE)
  ) u_ptr (
    .op(ptr_op_e'(ptr_op)), .sel(ptr_sel), .wdata(ptr_wdata),
    .cur(ptr_vals), .upd(ptr_upd), .lo_idx(ptr_lo_idx),
    .next(ptr_next), .addr(ptr_addr)
  );

  gprf_core #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .NUM_PTRS(NUM_PTRS), .PTR_BASE(PTR_BASE)
  ) u_core (
    .clk(clk), .rst(rst),
    .ra_sel(ra_sel), .ra_data(ra_data),
    .rb_sel(rb_sel), .rb_data(rb_data),
    .alu_we(wr_en), .alu_sel(wr_sel), .alu_wdata(wr_data),
    .ptr_upd(ptr_upd), .ptr_lo_idx(ptr_lo_idx), .ptr_next(ptr_next),
    .ds_we(ds_reg_we), .ds_sel(ds_reg_idx), .ds_wdata(ds_wdata),
    .ds_rdata(reg_ds_rdata), .ptr_vals(ptr_vals)
  );

  gprf_io_bank #(
    .DATA_W(DATA_W), .IO_REGS(IO_REGS)
  ) u_io (
    .clk(clk), .rst(rst),
    .dir_we(io_we), .dir_idx(io_addr), .dir_wdata(io_wdata),
    .dir_rdata(io_rdata),
    .ds_we(ds_io_we), .ds_idx(ds_io_idx), .ds_wdata(ds_wdata),
    .ds_rdata(io_ds_rdata)
  );

  always_comb begin
    unique case (region)
      RGN_REG: ds_rdata = reg_ds_rdata;
      RGN_IO:  ds_rdata = io_ds_rdata;
      default: ds_rdata = '0;
    endcase
  end

  assign ds_oor = (region == RGN_NONE);
  assign ptr_x  = ptr_vals[0];
  assign ptr_y  = ptr_vals[1];
  assign ptr_z  = ptr_vals[2];
endmodule

// File: rtl/gprf_checker.sv
module gprf_checker #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  parameter int IO_REGS  = 64,
  parameter int ADDR_W   = 16,
  parameter int PTR_BASE = 26,
  localparam int REG_IDX_W = $clog2(NUM_REGS),
  localparam int IO_IDX_W  = $clog2(IO_REGS),
  localparam int PTR_W     = 2 * DATA_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [REG_IDX_W-1:0] wr_sel,
  input logic [DATA_W-1:0]    wr_data,
  input logic [1:0]           ptr_op,
  input logic [1:0]           ptr_sel,
  input logic [PTR_W-1:0]     ptr_addr,
  input logic [PTR_W-1:0]     ptr_x,
  input logic [PTR_W-1:0]     ptr_y,
  input logic [PTR_W-1:0]     ptr_z,
  input logic [IO_IDX_W-1:0]  io_addr,
  input logic [DATA_W-1:0]    io_rdata,
  input logic [ADDR_W-1:0]    ds_addr,
  input logic                 ds_we,
  input logic [DATA_W-1:0]    ds_rdata,
  input logic                 ds_oor
);
  localparam logic [ADDR_W-1:0] IO_START = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] WIN_END  = ADDR_W'(NUM_REGS + IO_REGS);

  assert_alu_low_x_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == REG_IDX_W'(PTR_BASE)) |=> ptr_x[DATA_W-1:0] == $past(wr_data));

  assert_sel_none_R4: assert property (@(posedge clk) disable iff (rst)
    (ptr_sel == 2'd3 && !wr_en && !ds_we) |=>
      ($stable(ptr_x) && $stable(ptr_y) && $stable(ptr_z)));

  assert_postinc_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (ptr_op == 2'd2 && ptr_sel == 2'd0) |-> ptr_addr == ptr_x);

  assert_postinc_step_R5: assert property (@(posedge clk) disable iff (rst)
    (ptr_op == 2'd2 && ptr_sel == 2'd0 && !wr_en && !ds_we) |=>
      ptr_x == $past(ptr_x) + PTR_W'(1));

  assert_predec_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (ptr_op == 2'd3 && ptr_sel == 2'd2) |-> ptr_addr == ptr_z - PTR_W'(1));

  assert_io_alias_R8: assert property (@(posedge clk) disable iff (rst)
    (ds_addr >= IO_START && ds_addr < WIN_END &&
     ADDR_W'(io_addr) + IO_START == ds_addr) |-> ds_rdata == io_rdata);

  assert_out_of_range_R9: assert property (@(posedge clk) disable iff (rst)
    (ds_addr >= WIN_END) |-> (ds_oor && ds_rdata == '0));

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (ptr_x == '0 && ptr_y == '0 && ptr_z == '0));
endmodule

bind gprf_dataspace_file gprf_checker #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IO_REGS(IO_REGS),
  .ADDR_W(ADDR_W), .PTR_BASE(PTR_BASE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ptr_op(ptr_op), .ptr_sel(ptr_sel), .ptr_addr(ptr_addr),
  .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
  .io_addr(io_addr), .io_rdata(io_rdata),
  .ds_addr(ds_addr), .ds_we(ds_we), .ds_rdata(ds_rdata), .ds_oor(ds_oor)
);

// File: tb/tb_gprf_dataspace_file.sv
module tb_gprf_dataspace_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ra_sel = '0, rb_sel = '0, wr_sel = '0;
  logic [7:0]  ra_data, rb_data, wr_data = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  ptr_op = '0, ptr_sel = '0;
  logic [15:0] ptr_wdata = '0, ptr_addr, ptr_x, ptr_y, ptr_z;
  logic        io_we = 1'b0;
  logic [5:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic [15:0] ds_addr = '0;
  logic        ds_we = 1'b0;
  logic [7:0]  ds_wdata = '0, ds_rdata;
  logic        ds_oor;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  gprf_dataspace_file dut (
    .clk(clk), .rst(rst),
    .ra_sel(ra_sel), .ra_data(ra_data), .rb_sel(rb_sel), .rb_data(rb_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ptr_op(ptr_op), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
    .ptr_addr(ptr_addr), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata),
    .ds_rdata(ds_rdata), .ds_oor(ds_oor)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wr_en = 1'b0; ptr_op = 2'd0; ptr_sel = 2'd3;
    io_we = 1'b0; ds_we = 1'b0;
  endtask

  task automatic ptr_do(input logic [1:0] op, input logic [1:0] sel, input logic [15:0] val);
    ptr_op = op; ptr_sel = sel; ptr_wdata = val;
    tick();
    idle();
  endtask

  task automatic t_reset();
    ra_sel = 5'd0; rb_sel = 5'd31; io_addr = 6'd63; ds_addr = 16'h0045; #1;
    chk("R11 r0", {8'h0, ra_data}, 16'h0);
    chk("R11 r31", {8'h0, rb_data}, 16'h0);
    chk("R11 ptr_x", ptr_x, 16'h0);
    chk("R11 ptr_y", ptr_y, 16'h0);
    chk("R11 ptr_z", ptr_z, 16'h0);
    chk("R11 io63", {8'h0, io_rdata}, 16'h0);
    chk("R11 ds io", {8'h0, ds_rdata}, 16'h0);
  endtask

  task automatic t_alu();
    wr_en = 1'b1; wr_sel = 5'd5; wr_data = 8'hA5; ra_sel = 5'd5; #1;
    chk("R2 before edge", {8'h0, ra_data}, 16'h0);
    tick();
    wr_sel = 5'd17; wr_data = 8'h3C; tick(); idle();
    rb_sel = 5'd17; #1;
    chk("R2 r5", {8'h0, ra_data}, 16'h00A5);
    chk("R1 r17", {8'h0, rb_data}, 16'h003C);
    // read-modify-write in a single cycle
    wr_en = 1'b1; wr_sel = 5'd5; #1;
    wr_data = ra_data + 8'd1;
    tick(); idle(); #1;
    chk("R1 rmw", {8'h0, ra_data}, 16'h00A6);
  endtask

  task automatic t_ptr_load();
    ptr_do(2'd1, 2'd0, 16'h1234);
    ptr_do(2'd1, 2'd1, 16'hBEEF);
    ptr_do(2'd1, 2'd2, 16'h00FF);
    ra_sel = 5'd26; rb_sel = 5'd27; #1;
    chk("R4 x load", ptr_x, 16'h1234);
    chk("R3 r26 low", {8'h0, ra_data}, 16'h0034);
    chk("R3 r27 high", {8'h0, rb_data}, 16'h0012);
    chk("R4 y load", ptr_y, 16'hBEEF);
    ptr_do(2'd1, 2'd3, 16'h5555);
    chk("R4 none x", ptr_x, 16'h1234);
    chk("R4 none y", ptr_y, 16'hBEEF);
    chk("R4 none z", ptr_z, 16'h00FF);
    wr_en = 1'b1; wr_sel = 5'd31; wr_data = 8'h80; tick(); idle();
    chk("R3 z from r31", ptr_z, 16'h80FF);
    ra_sel = 5'd28; rb_sel = 5'd29; #1;
    chk("R3 y pair", {rb_data, ra_data}, 16'hBEEF);
  endtask

  task automatic t_postinc();
    ptr_do(2'd1, 2'd2, 16'hFFFF);
    ptr_op = 2'd2; ptr_sel = 2'd2; #1;
    chk("R5 addr z", ptr_addr, 16'hFFFF);
    tick(); idle();
    chk("R5 z wrap", ptr_z, 16'h0000);
    ptr_op = 2'd2; ptr_sel = 2'd0; #1;
    chk("R5 addr x", ptr_addr, 16'h1234);
    tick(); idle();
    chk("R5 x step", ptr_x, 16'h1235);
  endtask

  task automatic t_predec();
    ptr_op = 2'd3; ptr_sel = 2'd1; #1;
    chk("R6 addr y", ptr_addr, 16'hBEEE);
    tick(); idle();
    chk("R6 y step", ptr_y, 16'hBEEE);
    ptr_op = 2'd3; ptr_sel = 2'd2; #1;
    chk("R6 addr z wrap", ptr_addr, 16'hFFFF);
    tick(); idle();
    chk("R6 z wrap", ptr_z, 16'hFFFF);
  endtask

  task automatic t_ds_reg();
    ds_addr = 16'h0003; ds_we = 1'b1; ds_wdata = 8'h77; tick(); idle();
    ra_sel = 5'd3; #1;
    chk("R7 store reg3", {8'h0, ra_data}, 16'h0077);
    chk("R7 load reg3", {8'h0, ds_rdata}, 16'h0077);
    chk("R7 in range", {15'h0, ds_oor}, 16'h0);
    wr_en = 1'b1; wr_sel = 5'd9; wr_data = 8'h19; tick(); idle();
    ds_addr = 16'h0009; #1;
    chk("R7 load reg9", {8'h0, ds_rdata}, 16'h0019);
  endtask

  task automatic t_ds_io();
    ds_addr = 16'h0020; ds_we = 1'b1; ds_wdata = 8'h11; tick();
    ds_addr = 16'h005F; ds_wdata = 8'hEE; tick(); idle();
    io_addr = 6'd0; #1;
    chk("R8 io0", {8'h0, io_rdata}, 16'h0011);
    io_addr = 6'd63; #1;
    chk("R8 io63", {8'h0, io_rdata}, 16'h00EE);
    io_we = 1'b1; io_addr = 6'd10; io_wdata = 8'h4B; tick(); idle();
    ds_addr = 16'h002A; #1;
    chk("R8 direct seen by ds", {8'h0, ds_rdata}, 16'h004B);
    chk("R8 in range", {15'h0, ds_oor}, 16'h0);
  endtask

  task automatic t_oor();
    ds_addr = 16'h0060; #1;
    chk("R9 flag 0x60", {15'h0, ds_oor}, 16'h1);
    chk("R9 zero 0x60", {8'h0, ds_rdata}, 16'h0);
    ds_we = 1'b1; ds_wdata = 8'h99; tick();
    ds_addr = 16'h1060; tick(); idle();
    io_addr = 6'd0; ra_sel = 5'd0; #1;
    chk("R9 io0 kept", {8'h0, io_rdata}, 16'h0011);
    chk("R9 r0 kept", {8'h0, ra_data}, 16'h0);
    ds_addr = 16'hFFFF; #1;
    chk("R9 flag top", {15'h0, ds_oor}, 16'h1);
    chk("R9 zero top", {8'h0, ds_rdata}, 16'h0);
  endtask

  task automatic t_prio();
    wr_en = 1'b1; wr_sel = 5'd12; wr_data = 8'hAA;
    ds_we = 1'b1; ds_addr = 16'h000C; ds_wdata = 8'h55; tick();
    wr_sel = 5'd14; wr_data = 8'h44; ds_addr = 16'h000D; ds_wdata = 8'h33; tick(); idle();
    ra_sel = 5'd12; rb_sel = 5'd13; #1;
    chk("R10 alu over ds", {8'h0, ra_data}, 16'h00AA);
    chk("R10 separate ds", {8'h0, rb_data}, 16'h0033);
    ptr_op = 2'd1; ptr_sel = 2'd0; ptr_wdata = 16'hCAFE;
    wr_en = 1'b1; wr_sel = 5'd27; wr_data = 8'h01; tick(); idle();
    chk("R10 alu over ptr", ptr_x, 16'h01FE);
    ptr_op = 2'd1; ptr_sel = 2'd1; ptr_wdata = 16'h1111;
    ds_we = 1'b1; ds_addr = 16'h001C; ds_wdata = 8'h77; tick(); idle();
    chk("R10 ptr over ds", ptr_y, 16'h1111);
    io_we = 1'b1; io_addr = 6'd5; io_wdata = 8'hD1;
    ds_we = 1'b1; ds_addr = 16'h0025; ds_wdata = 8'h2D; tick(); idle();
    #1;
    chk("R10 direct over ds", {8'h0, io_rdata}, 16'h00D1);
  endtask

  task automatic t_rereset();
    rst = 1'b1; tick(); rst = 1'b0;
    io_addr = 6'd5; ra_sel = 5'd12; #1;
    chk("R11 x cleared", ptr_x, 16'h0);
    chk("R11 z cleared", ptr_z, 16'h0);
    chk("R11 io cleared", {8'h0, io_rdata}, 16'h0);
    chk("R11 r12 cleared", {8'h0, ra_data}, 16'h0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_alu();
    t_ptr_load();
    t_postinc();
    t_predec();
    t_ds_reg();
    t_ds_io();
    t_oor();
    t_prio();
    t_rereset();
    summary();
    $finish;
  end
endmodule